// File: doc/BRIEF.md
# SDRAM Page Scanner

This block drives an SDRAM through a display frame without any processor. It produces a command, a bank select and a shared row/column address at the memory clock rate, together with a column strobe and the column, page and pixel position of the word currently streaming out of the memory. Each page is one SDRAM row of 1024 columns. Only the first 1022 columns hold picture data, as 146 pixel transactions of 7 serial bits each. The last two columns are never read.

Just before the end of each page the block opens the next one. It sends a precharge, then an activate of the next row, then a read of that row's column 0. The read goes out exactly CAS-latency cycles before the column after the last used one would stream, so the new page's column 0 follows column 1021 with no gap. Pages step through banks 0, 1, 2, 3 in turn and move to a new row every four pages. After the last page of the frame, the link goes back to page 0 and never on into the unused memory beyond the frame.

A start pulse begins the sweep at page 0. A stop request lets the current frame finish and then returns the block to idle.

Top module: `page_scanner`

## Requirements
- R1: After reset, and whenever idle, `cmd` is NOP (encoding NOP=0, PRE=1, ACT=2, RD=3), `cmd_bank` and `cmd_addr` are 0, `stream_valid` is 0, and `stream_col`, `stream_page`, `pix_bit` and `pix_num` are 0.
- R2: Start is sampled by a clock edge while idle. In the next three cycles `cmd` shows PRE, then ACT with row 0 on `cmd_addr`, then RD with 0 on `cmd_addr`, all to bank 0. Exactly CAS_LAT cycles after the RD cycle, `stream_valid` rises with `stream_col`=0 and `stream_page`=0.
- R3: While streaming, `stream_col` rises by one per cycle from 0 to 1021 and never shows 1022 or 1023. Every cycle outside the page-opening slots issues NOP with bank and address 0.
- R4: While page p streams, the cycles at columns 1022-CAS_LAT-2, 1022-CAS_LAT-1 and 1022-CAS_LAT issue PRE, ACT and RD, in that order, to the page that follows p. The cycle after column 1021 streams column 0 of that page.
- R5: Page q is placed in bank q mod 4 and row q div 4. ACT carries the row on `cmd_addr`, RD carries column 0, and PRE carries 0.
- R6: On the last page (PAGES-1) the link commands aim at page 0: bank 0, row 0. After column 1021 the stream continues with page 0.
- R7: While streaming, `pix_bit` equals the column mod 7 (0..6) and `pix_num` equals the column div 7. Both are 0 at each page's column 0.
- R8: A stop seen by any clock edge from the start of the frame up to the edge that enters the last page's PRE slot replaces that page's three link commands with NOP. The stream ends after column 1021 and the block goes idle. A stop first seen by a later edge of the frame lets the following frame run, and that frame then ends the same way.
- R9: Start has no effect while a sweep is in progress. Stop has no effect while idle: a later start still runs a full frame that links back to page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep at page 0 (sampled while idle) |
| stop | input | 1 | End the sweep once the current frame is done |
| cmd | output | 2 | Memory command: 0 NOP, 1 PRE, 2 ACT, 3 RD |
| cmd_bank | output | BANK_W (2) | Bank addressed by the command |
| cmd_addr | output | ROW_W (13) | Row on ACT, column 0 on RD, else 0 |
| stream_valid | output | 1 | Column strobe: a used column is streaming this cycle |
| stream_col | output | COL_W (10) | Column now streaming |
| stream_page | output | PAGE_W (3) | Page now streaming |
| pix_bit | output | BIT_W (3) | Serial bit position inside the pixel transaction |
| pix_num | output | NUM_W (8) | Pixel transaction index in the page |

## Verification
Two functions can meet in the same cycle. One is the frame-wrap link decision on the last page. The other is a stop request arriving right at that decision. The bench asserts stop for one cycle at the last page's column just before the PRE slot, and in a second run for one cycle in the PRE slot itself. It then judges from the command port whether the three link commands became NOP and the stream went idle after column 1021, or whether one more full frame ran first. A cycle-level model built from the requirements is compared against every output on every cycle, so both outcomes are pinned to the exact cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_OPEN = 2'd1,
        MD_RUN  = 2'd2
    } mode_e;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int COLS_USED = 1022,
    parameter int CAS_LAT   = 2,
    parameter int PAGES     = 6,
    parameter int COL_W     = 10,
    parameter int PAGE_W    = 3,
    parameter int LEAD_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    output mode_e             mode,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page,
    output logic [LEAD_W-1:0] lead,
    output logic              halt
);

    localparam int LAST_COL = COLS_USED - 1;
    localparam int PRE_COL  = COLS_USED - CAS_LAT - 2;
    localparam int LEAD_END = 2 + CAS_LAT - 1;

    localparam logic [COL_W-1:0]  LAST_C  = COL_W'(LAST_COL);
    localparam logic [COL_W-1:0]  PRE_C   = COL_W'(PRE_COL);
    localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(PAGES - 1);
    localparam logic [LEAD_W-1:0] LEAD_C  = LEAD_W'(LEAD_END);

    typedef struct packed {
        mode_e              mode;
        logic [COL_W-1:0]   col;
        logic [PAGE_W-1:0]  page;
        logic [LEAD_W-1:0]  lead;
        logic               stop;
        logic               halt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.mode)
            MD_IDLE: begin
                if (start) begin
                    s_d.mode = MD_OPEN;
                    s_d.lead = '0;
                    s_d.page = '0;
                    s_d.col  = '0;
                    s_d.stop = 1'b0;
                    s_d.halt = 1'b0;
                end
            end
            MD_OPEN: begin
                s_d.stop = s_q.stop | stop;
                if (s_q.lead == LEAD_C) begin
                    s_d.mode = MD_RUN;
                    s_d.col  = '0;
                end else begin
                    s_d.lead = s_q.lead + 1'b1;
                end
            end
            MD_RUN: begin
                s_d.stop = s_q.stop | stop;
                if (s_q.col == LAST_C) begin
                    s_d.col = '0;
                    if (s_q.halt) begin
                        s_d.mode = MD_IDLE;
                        s_d.page = '0;
                        s_d.stop = 1'b0;
                        s_d.halt = 1'b0;
                    end else begin
                        s_d.page = (s_q.page == LAST_PG) ? '0 : s_q.page + 1'b1;
                    end
                end else begin
                    s_d.col = s_q.col + 1'b1;
                    if ((s_d.col == PRE_C) && (s_q.page == LAST_PG) &&
                        (s_q.stop || stop))
                        s_d.halt = 1'b1;
                end
            end
            default: s_d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MD_IDLE;
            s_q.col  <= '0;
            s_q.page <= '0;
            s_q.lead <= '0;
            s_q.stop <= 1'b0;
            s_q.halt <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode = s_q.mode;
    assign col  = s_q.col;
    assign page = s_q.page;
    assign lead = s_q.lead;
    assign halt = s_q.halt;

    assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_RUN) |-> (s_q.col <= LAST_C));

    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_RUN && s_q.col != LAST_C) |=>
        (s_q.mode == MD_RUN && s_q.col == $past(s_q.col) + 1'b1));

    assert_halt_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_RUN && s_q.col == LAST_C && s_q.halt) |=>
        (s_q.mode == MD_IDLE));

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_RUN && s_q.col != LAST_C) |=> (s_q.mode != MD_OPEN));

endmodule

// File: rtl/scan_cmd_gen.sv
module scan_cmd_gen
    import scan_pkg::*;
#(
    parameter int COLS_USED = 1022,
    parameter int CAS_LAT   = 2,
    parameter int PAGES     = 6,
    parameter int BANKS     = 4,
    parameter int COL_W     = 10,
    parameter int PAGE_W    = 3,
    parameter int LEAD_W    = 3,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13
) (
    input  mode_e             mode,
    input  logic [COL_W-1:0]  col,
    input  logic [PAGE_W-1:0] page,
    input  logic [LEAD_W-1:0] lead,
    input  logic              halt,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  addr
);

    localparam int PRE_COL = COLS_USED - CAS_LAT - 2;

    localparam logic [COL_W-1:0]  PRE_C   = COL_W'(PRE_COL);
    localparam logic [COL_W-1:0]  ACT_C   = COL_W'(PRE_COL + 1);
    localparam logic [COL_W-1:0]  RD_C    = COL_W'(PRE_COL + 2);
    localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(PAGES - 1);

    logic [PAGE_W-1:0] tgt;
    cmd_e              sel;

    always_comb begin
        sel = CMD_NOP;
        tgt = '0;
        if (mode == MD_OPEN) begin
            tgt = '0;
            case (lead)
                LEAD_W'(0): sel = CMD_PRE;
                LEAD_W'(1): sel = CMD_ACT;
                LEAD_W'(2): sel = CMD_RD;
                default:    sel = CMD_NOP;
            endcase
        end else if (mode == MD_RUN && !halt) begin
            tgt = (page == LAST_PG) ? '0 : page + 1'b1;
            if (col == PRE_C)      sel = CMD_PRE;
            else if (col == ACT_C) sel = CMD_ACT;
            else if (col == RD_C)  sel = CMD_RD;
        end
    end

    always_comb begin
        cmd  = sel;
        bank = '0;
        addr = '0;
        if (sel != CMD_NOP)
            bank = BANK_W'(int'(tgt) % BANKS);
        if (sel == CMD_ACT)
            addr = ROW_W'(int'(tgt) / BANKS);
    end

endmodule

// File: rtl/scan_pix_count.sv
module scan_pix_count #(
    parameter int GROUP = 7,
    parameter int BIT_W = 3,
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             last,
    output logic [BIT_W-1:0] bit_o,
    output logic [NUM_W-1:0] num_o
);

    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(GROUP - 1);

    typedef struct packed {
        logic [BIT_W-1:0] pbit;
        logic [NUM_W-1:0] pnum;
    } pix_t;

    pix_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!valid || last) begin
            p_d.pbit = '0;
            p_d.pnum = '0;
        end else if (p_q.pbit == BIT_TOP) begin
            p_d.pbit = '0;
            p_d.pnum = p_q.pnum + 1'b1;
        end else begin
            p_d.pbit = p_q.pbit + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.pbit <= '0;
            p_q.pnum <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign bit_o = p_q.pbit;
    assign num_o = p_q.pnum;

    assert_bit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.pbit <= BIT_TOP);

    assert_bit_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last && p_q.pbit == BIT_TOP) |=> (p_q.pbit == '0));

endmodule

// File: rtl/page_scanner.sv
module page_scanner
    import scan_pkg::*;
#(
    parameter int COLS_USED = 1022,
    parameter int CAS_LAT   = 2,
    parameter int PAGES     = 6,
    parameter int BANKS     = 4,
    parameter int GROUP     = 7,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int LEAD_W    = 3,
    parameter int PAGE_W    = $clog2(PAGES),
    parameter int BANK_W    = $clog2(BANKS),
    parameter int BIT_W     = $clog2(GROUP),
    parameter int NUM_W     = $clog2(COLS_USED / GROUP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              stream_valid,
    output logic [COL_W-1:0]  stream_col,
    output logic [PAGE_W-1:0] stream_page,
    output logic [BIT_W-1:0]  pix_bit,
    output logic [NUM_W-1:0]  pix_num
);

    localparam logic [COL_W-1:0] LAST_C = COL_W'(COLS_USED - 1);

    mode_e             mode_w;
    logic [COL_W-1:0]  col_w;
    logic [PAGE_W-1:0] page_w;
    logic [LEAD_W-1:0] lead_w;
    logic              halt_w;
    cmd_e              cmd_w;
    logic              run_w;

    scan_ctrl #(
        .COLS_USED(COLS_USED), .CAS_LAT(CAS_LAT), .PAGES(PAGES),
        .COL_W(COL_W), .PAGE_W(PAGE_W), .LEAD_W(LEAD_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .mode(mode_w), .col(col_w), .page(page_w), .lead(lead_w), .halt(halt_w)
    );

    scan_cmd_gen #(
        .COLS_USED(COLS_USED), .CAS_LAT(CAS_LAT), .PAGES(PAGES), .BANKS(BANKS),
        .COL_W(COL_W), .PAGE_W(PAGE_W), .LEAD_W(LEAD_W), .BANK_W(BANK_W),
        .ROW_W(ROW_W)
    ) u_cmd (
        .mode(mode_w), .col(col_w), .page(page_w), .lead(lead_w), .halt(halt_w),
        .cmd(cmd_w), .bank(cmd_bank), .addr(cmd_addr)
    );

    assign run_w = (mode_w == MD_RUN);

    scan_pix_count #(
        .GROUP(GROUP), .BIT_W(BIT_W), .NUM_W(NUM_W)
    ) u_pix (
        .clk(clk), .rst_n(rst_n), .valid(run_w), .last(col_w == LAST_C),
        .bit_o(pix_bit), .num_o(pix_num)
    );

    assign cmd          = cmd_w;
    assign stream_valid = run_w;
    assign stream_col   = col_w;
    assign stream_page  = page_w;

    assert_act_after_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_ACT) |-> ($past(cmd_w) == CMD_PRE));

    assert_rd_after_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_RD) |-> ($past(cmd_w) == CMD_ACT));

    assert_stream_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_valid) |-> (stream_col == '0 && stream_page == '0));

    assert_pix_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_valid && stream_col == '0) |-> (pix_bit == '0 && pix_num == '0));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MD_IDLE) |-> (cmd_w == CMD_NOP && !stream_valid));

endmodule

// File: tb/page_scanner_test.sv
module page_scanner_test;

    localparam int USED  = 1022;
    localparam int CL    = 2;
    localparam int NP    = 6;
    localparam int LAST  = USED - 1;
    localparam int PRE_S = USED - CL - 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [1:0]  cmd;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        stream_valid;
    logic [9:0]  stream_col;
    logic [2:0]  stream_page;
    logic [2:0]  pix_bit;
    logic [7:0]  pix_num;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_mode = 0, m_lead = 0, m_col = 0, m_page = 0, m_stop = 0, m_halt = 0;

    page_scanner uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .stream_valid(stream_valid), .stream_col(stream_col),
        .stream_page(stream_page), .pix_bit(pix_bit), .pix_num(pix_num)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the cycle model built from the requirements.
    task automatic compare_model();
        int tgt, e_cmd, e_bank, e_addr, e_valid;
        e_cmd = 0; e_bank = 0; e_addr = 0; tgt = 0;
        e_valid = (m_mode == 2) ? 1 : 0;
        if (m_mode == 1) begin
            if (m_lead == 0) e_cmd = 1;
            else if (m_lead == 1) e_cmd = 2;
            else if (m_lead == 2) e_cmd = 3;
        end else if (m_mode == 2 && m_halt == 0) begin
            tgt = (m_page == NP - 1) ? 0 : m_page + 1;
            if (m_col == PRE_S) e_cmd = 1;
            else if (m_col == PRE_S + 1) e_cmd = 2;
            else if (m_col == PRE_S + 2) e_cmd = 3;
        end
        if (e_cmd != 0) e_bank = tgt % 4;
        if (e_cmd == 2) e_addr = tgt / 4;
        chk(cmd == e_cmd, "R4 model cmd", cmd, e_cmd);
        chk(cmd_bank == e_bank, "R5 model bank", cmd_bank, e_bank);
        chk(cmd_addr == e_addr, "R5 model addr", cmd_addr, e_addr);
        chk(stream_valid == e_valid, "R3 model valid", stream_valid, e_valid);
        chk(stream_col == m_col, "R3 model col", stream_col, m_col);
        chk(stream_page == m_page, "R6 model page", stream_page, m_page);
        chk(pix_bit == (e_valid ? m_col % 7 : 0), "R7 model bit", pix_bit,
            e_valid ? m_col % 7 : 0);
        chk(pix_num == (e_valid ? m_col / 7 : 0), "R7 model num", pix_num,
            e_valid ? m_col / 7 : 0);
    endtask

    task automatic step();
        int st, sp, nst;
        st = start; sp = stop;
        case (m_mode)
            0: if (st) begin
                m_mode = 1; m_lead = 0; m_page = 0; m_col = 0; m_stop = 0; m_halt = 0;
            end
            1: begin
                m_stop = m_stop | sp;
                if (m_lead == 2 + CL - 1) begin m_mode = 2; m_col = 0; end
                else m_lead++;
            end
            default: begin
                nst = m_stop | sp;
                if (m_col == LAST) begin
                    m_col = 0;
                    if (m_halt) begin
                        m_mode = 0; m_page = 0; m_stop = 0; m_halt = 0;
                    end else begin
                        m_page = (m_page == NP - 1) ? 0 : m_page + 1;
                        m_stop = nst;
                    end
                end else begin
                    if (m_col + 1 == PRE_S && m_page == NP - 1 && (m_stop || sp))
                        m_halt = 1;
                    m_col++;
                    m_stop = nst;
                end
            end
        endcase
        @(negedge clk);
        compare_model();
    endtask

    task automatic run_until(input int p, input int c);
        for (int n = 0; n < 20000; n++) begin
            if (m_mode == 2 && m_page == p && m_col == c) return;
            step();
        end
        chk(0, "R3 run_until reach", m_col, c);
    endtask

    task automatic t_reset();
        chk(cmd == 0, "R1 reset cmd", cmd, 0);
        chk(stream_valid == 0, "R1 reset valid", stream_valid, 0);
        chk(cmd_addr == 0 && cmd_bank == 0, "R1 reset addr", cmd_addr, 0);
        chk(pix_bit == 0 && pix_num == 0, "R1 reset pixel", pix_num, 0);
    endtask

    task automatic t_stop_idle();
        stop = 1; step(); stop = 0;
        for (int i = 0; i < 4; i++) step();
        chk(cmd == 0 && stream_valid == 0, "R9 stop while idle stays idle", cmd, 0);
    endtask

    task automatic t_start();
        start = 1; step(); start = 0;
        chk(cmd == 1 && cmd_bank == 0, "R2 open PRE", cmd, 1);
        step();
        chk(cmd == 2 && cmd_addr == 0, "R2 open ACT row0", cmd, 2);
        step();
        chk(cmd == 3 && cmd_addr == 0 && cmd_bank == 0, "R2 open RD col0", cmd, 3);
        for (int i = 1; i < CL; i++) begin
            step();
            chk(stream_valid == 0 && cmd == 0, "R2 latency gap", stream_valid, 0);
        end
        step();
        chk(stream_valid == 1 && stream_col == 0 && stream_page == 0,
            "R2 first column", stream_col, 0);
    endtask

    task automatic t_pixels();
        run_until(0, 15);
        chk(pix_bit == 1 && pix_num == 2, "R7 pixel at col 15", pix_num, 2);
    endtask

    task automatic t_start_busy();
        int c0;
        run_until(0, 300);
        c0 = stream_col;
        start = 1; step(); start = 0;
        chk(stream_col == c0 + 1 && cmd == 0, "R9 start ignored while busy",
            stream_col, c0 + 1);
    endtask

    task automatic t_page_turn();
        run_until(0, PRE_S - 1);
        chk(cmd == 0, "R3 nop before slot", cmd, 0);
        step();
        chk(cmd == 1 && cmd_bank == 1, "R4 PRE next bank", cmd_bank, 1);
        step();
        chk(cmd == 2 && cmd_bank == 1 && cmd_addr == 0, "R4 ACT next page", cmd, 2);
        step();
        chk(cmd == 3 && cmd_bank == 1 && cmd_addr == 0, "R4 RD column 0", cmd, 3);
        run_until(0, LAST);
        step();
        chk(stream_valid && stream_col == 0 && stream_page == 1,
            "R4 gapless page change", stream_page, 1);
    endtask

    task automatic t_bank_row();
        run_until(3, PRE_S + 1);
        chk(cmd == 2 && cmd_bank == 0 && cmd_addr == 1, "R5 page 4 bank0 row1",
            cmd_addr, 1);
        run_until(4, PRE_S + 1);
        chk(cmd == 2 && cmd_bank == 1 && cmd_addr == 1, "R5 page 5 bank1 row1",
            cmd_bank, 1);
    endtask

    task automatic t_wrap();
        run_until(NP - 1, PRE_S);
        chk(cmd == 1 && cmd_bank == 0, "R6 wrap PRE bank0 (R9 not halted)", cmd, 1);
        step();
        chk(cmd == 2 && cmd_addr == 0 && cmd_bank == 0, "R6 wrap ACT row0", cmd_addr, 0);
        run_until(NP - 1, LAST);
        step();
        chk(stream_page == 0 && stream_col == 0 && stream_valid, "R6 back to page 0",
            stream_page, 0);
    endtask

    task automatic t_stop_late();
        run_until(NP - 1, PRE_S);
        stop = 1; step(); stop = 0;
        chk(cmd == 2, "R8 late stop keeps link", cmd, 2);
        run_until(0, 0);
        chk(stream_valid == 1, "R8 late stop next frame", stream_valid, 1);
        run_until(NP - 1, PRE_S);
        chk(cmd == 0, "R8 latched stop suppresses PRE", cmd, 1 - 1);
        step();
        chk(cmd == 0, "R8 latched stop suppresses ACT", cmd, 0);
        run_until(NP - 1, LAST);
        step();
        chk(stream_valid == 0 && cmd == 0, "R8 idle after frame", stream_valid, 0);
        for (int i = 0; i < 5; i++) step();
        chk(cmd == 0 && stream_valid == 0, "R1 stays idle", cmd, 0);
    endtask

    task automatic t_stop_edge();
        start = 1; step(); start = 0;
        run_until(NP - 1, PRE_S - 1);
        stop = 1; step(); stop = 0;
        chk(cmd == 0, "R8 edge stop suppresses PRE", cmd, 0);
        step(); step();
        chk(cmd == 0, "R8 edge stop suppresses RD", cmd, 0);
        run_until(NP - 1, LAST);
        step();
        chk(stream_valid == 0 && stream_page == 0, "R8 edge stop ends sweep",
            stream_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_model();
        t_reset();
        t_stop_idle();
        t_start();
        t_pixels();
        t_start_busy();
        t_page_turn();
        t_bank_row();
        t_wrap();
        t_stop_late();
        t_stop_edge();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule